// File: doc/BRIEF.md
# 64b/66b Self-Synchronous Scrambler Pair

This block whitens the 64-bit payload of every 66-bit line block before it goes to a transceiver, and restores it on the return path. Both directions handle one full block per clock. They use the self-synchronous polynomial x^58 + x^39 + 1. The result is bit-for-bit the same as a serial scrambler that takes the payload least-significant bit first. The 2-bit sync header is never scrambled; it is delayed by the same single register stage as the payload.

The transmit path scrambles first and then, if asked, reverses the bit order. The receive path reverses first, if asked, and then descrambles. The reversal serves transceivers that shift the most significant bit out first. Each direction has its own scramble enable. While an enable is low, the payload of that direction passes through unchanged and its 58-bit history register keeps its value. The descrambler takes its feedback from the received line bits. After any 58 or more bits it therefore agrees with the far end, whatever state it started from.

Top module: `scr_pair_66b`

## Requirements
- R1: With tx_scr_en_i high, each transmit payload bit i is computed in order from bit 0 to bit 63. Its output is the input bit XOR history bit 38 XOR history bit 57. After each bit the history shifts left by one, and that output bit enters at history bit 0.
- R2: With rx_scr_en_i high, each receive payload bit i is computed in order from bit 0 to bit 63. Its output is the line bit XOR history bit 38 XOR history bit 57. After each bit the history shifts left by one, and the line bit (not the output) enters at history bit 0.
- R3: The sync headers tx_hdr_o and rx_hdr_o equal the header inputs of the previous clock. They are never scrambled, and their only change is the reversal of R4 or R5.
- R4: When rev_en_i is high, the transmit path scrambles first and then maps payload bit i to bit 63-i and header bit i to bit 1-i.
- R5: When rev_en_i is high, the receive path first maps line payload bit i to bit 63-i and header bit i to bit 1-i, then descrambles.
- R6: While a direction's scramble enable is low, its payload passes through unchanged (apart from reversal) and its history register holds its value.
- R7: Reset (rst_ni low, asynchronous) clears both history registers and all outputs to zero.
- R8: For any starting state, a descrambler fed by the scrambler's output returns the original payload from the second looped block onward.
- R9: Each output block appears exactly one clock after the input block that produced it, and one block is accepted every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rev_en_i | input | 1 | Bit-order reversal for both directions |
| tx_scr_en_i | input | 1 | Transmit scramble enable |
| tx_hdr_i | input | 2 | Transmit sync header |
| tx_data_i | input | 64 | Transmit payload |
| tx_hdr_o | output | 2 | Transmit header to line |
| tx_data_o | output | 64 | Scrambled transmit payload to line |
| rx_scr_en_i | input | 1 | Receive descramble enable |
| rx_hdr_i | input | 2 | Receive header from line |
| rx_data_i | input | 64 | Receive payload from line |
| rx_hdr_o | output | 2 | Receive header out |
| rx_data_o | output | 64 | Descrambled receive payload |

## Verification
The hardest case to reach from the ports is a descrambler whose history has nothing in common with the scrambler feeding it, because both histories start at zero after reset. To get there, the bench first sends random line blocks into the receive path while the transmit path scrambles other data. It then loops transmit output back into receive input, with reversal on at both ends. From the second looped block onward, it expects the original payload one cycle behind.

// File: rtl/scr_pkg.sv
package scr_pkg;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned HDR_W  = 2;
  parameter int unsigned HIST_W = 58;
  parameter int unsigned TAP_A  = 38;
  parameter int unsigned TAP_B  = 57;

  localparam int unsigned RES_W = HIST_W + DATA_W;

  // Parallel form of the serial LSB-first scrambler; returns {next_history, out}.
  function automatic logic [RES_W-1:0] scr_block(input logic [DATA_W-1:0] din,
                                                 input logic [HIST_W-1:0] hist,
                                                 input logic              feed_line);
    logic [HIST_W-1:0] h;
    logic [DATA_W-1:0] o;
    h = hist;
    for (int i = 0; i < DATA_W; i++) begin
      o[i] = din[i] ^ h[TAP_A] ^ h[TAP_B];
      h    = {h[HIST_W-2:0], feed_line ? din[i] : o[i]};
    end
    return {h, o};
  endfunction
endpackage

// File: rtl/bit_order.sv
module bit_order #(
  parameter int unsigned W = 64
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign d_o[i] = en_i ? d_i[W-1-i] : d_i[i];
  end
endmodule

// File: rtl/scr_core.sv
module scr_core
  import scr_pkg::*;
#(
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] d_o
);
  logic [HIST_W-1:0] hist_q;
  logic [RES_W-1:0]  res;
  logic [DATA_W-1:0] scr_out;
  logic              last_fb;

  assign res     = scr_block(d_i, hist_q, DESCRAMBLE);
  assign scr_out = res[DATA_W-1:0];
  assign d_o     = en_i ? scr_out : d_i;
  assign last_fb = DESCRAMBLE ? d_i[DATA_W-1] : scr_out[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (en_i) hist_q <= res[RES_W-1:DATA_W];
  end

  // R6
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hist_q));

  // R1 R2: newest history bit is the last fed-back bit of the block
  hist_feed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> hist_q[0] == $past(last_fb));
endmodule

// File: rtl/scr_pair_66b.sv
module scr_pair_66b
  import scr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev_en_i,
  input  logic              tx_scr_en_i,
  input  logic [HDR_W-1:0]  tx_hdr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [HDR_W-1:0]  tx_hdr_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              rx_scr_en_i,
  input  logic [HDR_W-1:0]  rx_hdr_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [HDR_W-1:0]  rx_hdr_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [DATA_W-1:0] tx_scr, tx_line, rx_line, rx_plain;
  logic [HDR_W-1:0]  tx_hdr_line, rx_hdr_line;

  // transmit: scramble, then reorder
  scr_core #(.DESCRAMBLE(1'b0)) i_tx_core (
    .clk_i, .rst_ni, .en_i(tx_scr_en_i), .d_i(tx_data_i), .d_o(tx_scr));
  bit_order #(.W(DATA_W)) i_tx_rev  (.en_i(rev_en_i), .d_i(tx_scr),   .d_o(tx_line));
  bit_order #(.W(HDR_W))  i_tx_hrev (.en_i(rev_en_i), .d_i(tx_hdr_i), .d_o(tx_hdr_line));

  // receive: reorder, then descramble
  bit_order #(.W(DATA_W)) i_rx_rev  (.en_i(rev_en_i), .d_i(rx_data_i), .d_o(rx_line));
  bit_order #(.W(HDR_W))  i_rx_hrev (.en_i(rev_en_i), .d_i(rx_hdr_i),  .d_o(rx_hdr_line));
  scr_core #(.DESCRAMBLE(1'b1)) i_rx_core (
    .clk_i, .rst_ni, .en_i(rx_scr_en_i), .d_i(rx_line), .d_o(rx_plain));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= '0;
      tx_hdr_o  <= '0;
      rx_data_o <= '0;
      rx_hdr_o  <= '0;
    end else begin
      tx_data_o <= tx_line;
      tx_hdr_o  <= tx_hdr_line;
      rx_data_o <= rx_plain;
      rx_hdr_o  <= rx_hdr_line;
    end
  end

  // R3
  tx_hdr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tx_hdr_o == ($past(rev_en_i) ? {$past(tx_hdr_i[0]), $past(tx_hdr_i[1])}
                                          : $past(tx_hdr_i)));
  // R3
  rx_hdr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rx_hdr_o == ($past(rev_en_i) ? {$past(rx_hdr_i[0]), $past(rx_hdr_i[1])}
                                          : $past(rx_hdr_i)));
  // R6
  tx_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_scr_en_i && !rev_en_i) |=> tx_data_o == $past(tx_data_i));
  // R6
  rx_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_scr_en_i && !rev_en_i) |=> rx_data_o == $past(rx_data_i));
endmodule

// File: tb/test_scr_pair_66b.sv
module test_scr_pair_66b;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, rev = 1'b0;
  logic        tx_en = 1'b0, rx_en = 1'b0;
  logic [1:0]  tx_h = '0, rx_h = '0, tx_ho, rx_ho;
  logic [63:0] tx_d = '0, rx_d = '0, tx_do, rx_do;

  int checks = 0, errors = 0;
  logic [57:0] m_tx = '0, m_rx = '0;
  logic [63:0] e_tx_d, e_rx_d;
  logic [1:0]  e_tx_h, e_rx_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_pair_66b i_scr_pair_66b (
    .clk_i(clk), .rst_ni(rst_n), .rev_en_i(rev),
    .tx_scr_en_i(tx_en), .tx_hdr_i(tx_h), .tx_data_i(tx_d),
    .tx_hdr_o(tx_ho), .tx_data_o(tx_do),
    .rx_scr_en_i(rx_en), .rx_hdr_i(rx_h), .rx_data_i(rx_d),
    .rx_hdr_o(rx_ho), .rx_data_o(rx_do));

  initial begin
    #(CLK_PERIOD*50000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [63:0] flip64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[63-i] = v[i];
    return r;
  endfunction

  // serial reference; feed_line selects receive-side feedback
  task automatic ref_scr(input logic [63:0] din, inout logic [57:0] st,
                         input logic feed_line, output logic [63:0] dout);
    for (int i = 0; i < 64; i++) begin
      dout[i] = din[i] ^ st[38] ^ st[57];
      st = (st << 1) | 58'(feed_line ? din[i] : dout[i]);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, expect after one posedge (R9)
  task automatic step(input string tag);
    logic [63:0] t, r;
    if (tx_en) ref_scr(tx_d, m_tx, 1'b0, t); else t = tx_d;
    e_tx_d = rev ? flip64(t) : t;
    e_tx_h = rev ? {tx_h[0], tx_h[1]} : tx_h;
    r = rev ? flip64(rx_d) : rx_d;
    if (rx_en) ref_scr(r, m_rx, 1'b1, e_rx_d); else e_rx_d = r;
    e_rx_h = rev ? {rx_h[0], rx_h[1]} : rx_h;
    @(posedge clk); @(negedge clk);
    chk(tx_do == e_tx_d, {tag, " tx_data R1 R4 R9"}, tx_do, e_tx_d);
    chk(rx_do == e_rx_d, {tag, " rx_data R2 R5 R9"}, rx_do, e_rx_d);
    chk(tx_ho == e_tx_h && rx_ho == e_rx_h, {tag, " hdr R3"}, {tx_ho, rx_ho}, {e_tx_h, e_rx_h});
  endtask

  initial begin
    logic [63:0] prev_p, p;
    void'($urandom(32'h5eed_0042));
    #(CLK_PERIOD*2 + 1);
    // R7
    chk(tx_do == 0 && rx_do == 0 && tx_ho == 0 && rx_ho == 0, "reset outputs R7", tx_do ^ rx_do, 0);
    @(negedge clk); rst_n = 1'b1;

    // R7 R1: zero history, zero payload scrambles to zero
    tx_en = 1; rx_en = 1; tx_d = '0; rx_d = '0; tx_h = 2'b01;
    step("zero-state R7");
    chk(tx_do == 0, "zero history R7", tx_do, 0);

    // R4: single set bit, scrambling off, reversal on
    tx_en = 0; rx_en = 0; rev = 1; tx_d = 64'h1; rx_d = 64'h8000_0000_0000_0000; tx_h = 2'b10; rx_h = 2'b01;
    step("rev-single R4 R5");
    chk(tx_do == 64'h8000_0000_0000_0000 && tx_ho == 2'b01, "rev map R4", tx_do, 64'h8000_0000_0000_0000);
    chk(rx_do == 64'h1 && rx_ho == 2'b10, "rev map R5", rx_do, 64'h1);

    // R1 R2: directed all-ones
    rev = 0; tx_en = 1; rx_en = 1; tx_d = '1; rx_d = '1;
    step("ones R1 R2");

    // R6: bypass several blocks, then resume; model holds history
    tx_en = 0; rx_en = 0;
    for (int k = 0; k < 5; k++) begin
      tx_d = {$urandom, $urandom}; rx_d = {$urandom, $urandom};
      step("bypass R6");
      chk(tx_do == tx_d && rx_do == rx_d, "bypass pass R6", tx_do, tx_d);
    end
    tx_en = 1; rx_en = 1;
    for (int k = 0; k < 3; k++) begin
      tx_d = {$urandom, $urandom}; rx_d = {$urandom, $urandom};
      step("resume R6");
    end

    // random mix of enables, reversal, headers
    for (int k = 0; k < 300; k++) begin
      tx_en = $urandom_range(0, 3) != 0; rx_en = $urandom_range(0, 3) != 0;
      rev = $urandom_range(0, 1) == 1;
      tx_h = 2'($urandom); rx_h = 2'($urandom);
      tx_d = {$urandom, $urandom}; rx_d = {$urandom, $urandom};
      step("random R1 R2 R3");
    end

    // R8: desync receive history with random line blocks, then loop back
    tx_en = 1; rx_en = 1; rev = 1;
    for (int k = 0; k < 4; k++) begin
      rx_d = {$urandom, $urandom}; tx_d = {$urandom, $urandom};
      step("desync R8");
    end
    prev_p = tx_d;
    for (int k = 0; k < 20; k++) begin
      p = {$urandom, $urandom};
      rx_d = tx_do; rx_h = tx_ho; tx_d = p;
      step("loop R8");
      if (k >= 1) chk(rx_do == prev_p, "self-sync R8", rx_do, prev_p);
      prev_p = p;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule